// File: doc/BRIEF.md
# Capacity Allocation Configuration Controller

This block keeps the allocation table of a capacity-managed controller such as a cache. For every pair of resource-control ID and access type it stores a bitmask of the capacity blocks that the pair may allocate into, and a cap on the number of capacity units the pair may occupy there. The victim selector reads the table through its own combinational lookup port. The block also issues a flush request for an ID toward the cache and waits for the acknowledge. The flush walk itself happens elsewhere.

Software works through three 64-bit registers. It first stages a block mask and a unit limit. It then writes an operation into the control register. The operation can commit the staged pair to the table, copy a stored pair back into the staging registers, or request a flush of an ID. The control register reports a busy flag while the operation runs. It reports a completion code once the operation ends. While the busy flag is set, software writes to all three registers are dropped.

Register addresses are 0 for control, 1 for the unit limit, and 2 and up for the 64-bit words of the mask. Control word fields: operation in bits 4:0, access type in bits 7:5, ID in bits 19:8, completion code in bits 38:32, busy in bit 39. All other bits read as zero.

Top module: `cap_alloc_ctrl`

## Requirements
- R1: After reset, every table entry of ID 0 holds an all-ones mask and a limit of 0. Every other entry holds zero. The control register reads as zero.
- R2: An accepted control write reads back the written operation, access type and ID, with busy set in the following cycle. A configure or read-back operation clears busy one cycle later, with a completion code from 1 to 5.
- R3: Operation 1 with valid fields stores the staged mask and limit for the ID and access type, and completes with code 1. The lookup port returns the stored pair. It returns zero for an ID at or above the ID count, or for an access type at or above the access-type count.
- R4: Operation 2 with valid fields copies the stored mask and limit into the staging registers, and completes with code 1.
- R5: An operation code other than 1, 2 or 3 completes with code 2. This check comes first. The table and the staging registers stay unchanged.
- R6: An ID at or above the ID count (default 16) completes with code 3 when the operation code is valid.
- R7: For operations 1 and 2 with a valid ID, an access type at or above the access-type count (default 4) completes with code 4. Operation 3 does not check the access type.
- R8: Operation 1 with an all-zero staged mask completes with code 5 and leaves the table unchanged.
- R9: Mask bits at or above the block count (default 16) and limit bits at or above the limit width (default 20) read as zero.
- R10: While busy is set, writes to the control, mask and limit registers have no effect.
- R11: Operation 3 with a valid ID raises the flush request, carrying the ID, one cycle after busy rises. The request holds until an acknowledge is sampled. On the edge where the acknowledge is sampled, busy clears with code 1, and the table stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | AW | Register write address |
| reg_wr_data | input | 64 | Register write data |
| reg_rd_addr | input | AW | Register read address |
| reg_rd_data | output | 64 | Register read data (combinational) |
| tbl_rcid | input | 12 | Lookup ID from the victim selector |
| tbl_at | input | 3 | Lookup access type |
| tbl_mask | output | NBLK | Allocated block mask for the lookup |
| tbl_limit | output | CU_W | Unit limit for the lookup (0 means no limit) |
| flush_req | output | 1 | Flush request toward the cache |
| flush_rcid | output | 12 | ID to flush |
| flush_ack | input | 1 | Flush complete |

## Verification
The hardest case to reach is a register write that lands while an operation is still running. The read-back and configure operations stay busy for only one cycle, and their execute edge is the same edge as that write. The bench therefore drives a mask write in exactly the cycle after each marked control write. During a flush it holds off the acknowledge for a random number of cycles and fires random control, mask and limit writes in that window. Afterwards it shows, through the register reads and the lookup port, that none of those writes had any effect. Random ID and access-type values are biased just past their valid ranges, so that the ordering of the error codes is exercised.

// File: rtl/cap_alloc_pkg.sv
package cap_alloc_pkg;
   localparam int unsigned REG_W    = 64;
   localparam int unsigned OP_W     = 5;
   localparam int unsigned AT_LSB   = 5;
   localparam int unsigned AT_W     = 3;
   localparam int unsigned ID_LSB   = 8;
   localparam int unsigned ID_W     = 12;
   localparam int unsigned ST_LSB   = 32;
   localparam int unsigned ST_W     = 7;
   localparam int unsigned BUSY_BIT = 39;

   localparam logic [OP_W-1:0] OPC_SET   = 5'd1;
   localparam logic [OP_W-1:0] OPC_GET   = 5'd2;
   localparam logic [OP_W-1:0] OPC_FLUSH = 5'd3;

   typedef enum logic [ST_W-1:0] {
      ST_NONE     = 7'd0,
      ST_OK       = 7'd1,
      ST_BAD_OP   = 7'd2,
      ST_BAD_ID   = 7'd3,
      ST_BAD_AT   = 7'd4,
      ST_BAD_MASK = 7'd5
   } status_e;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_EXEC,
      SQ_FLUSH
   } seq_state_e;
endpackage

// File: rtl/cap_alloc_regs.sv
module cap_alloc_regs
   import cap_alloc_pkg::*;
#(
   parameter int NBLK       = 16,
   parameter int MASK_WORDS = 1,
   parameter int CU_W       = 20,
   parameter bit HAS_CU     = 1'b1,
   parameter bit PER_AT     = 1'b1,
   parameter int AW         = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [REG_W-1:0] wr_data,
   input  logic [AW-1:0]    rd_addr,
   output logic [REG_W-1:0] rd_data,
   input  logic             busy,
   input  status_e          status,
   input  logic             ld_stage,
   input  logic [NBLK-1:0]  ld_mask,
   input  logic [CU_W-1:0]  ld_limit,
   output logic             ctl_go,
   output logic [OP_W-1:0]  op,
   output logic [AT_W-1:0]  at,
   output logic [ID_W-1:0]  rcid,
   output logic [NBLK-1:0]  stage_mask,
   output logic [CU_W-1:0]  stage_limit
);
   localparam int BMW = MASK_WORDS * REG_W;
   localparam logic [AW-1:0] A_CTL = AW'(0);
   localparam logic [AW-1:0] A_LIM = AW'(1);

   logic           wr_ok;
   logic [BMW-1:0] mask_pad;
   logic           unused_data;

   assign wr_ok       = wr_en && !busy;
   assign ctl_go      = wr_ok && (wr_addr == A_CTL);
   assign unused_data = ^{wr_data, ld_limit};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op   <= '0;
         rcid <= '0;
      end else if (ctl_go) begin
         op   <= wr_data[OP_W-1:0];
         rcid <= wr_data[ID_LSB +: ID_W];
      end
   end

   generate
      if (PER_AT) begin : g_at
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      at <= '0;
            else if (ctl_go) at <= wr_data[AT_LSB +: AT_W];
         end
      end else begin : g_no_at
         assign at = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_mask <= '0;
      end else if (ld_stage) begin
         stage_mask <= ld_mask;
      end else if (wr_ok) begin
         for (int i = 0; i < NBLK; i++) begin
            if (wr_addr == AW'(2 + i / REG_W))
               stage_mask[i] <= wr_data[i % REG_W];
         end
      end
   end

   generate
      if (HAS_CU) begin : g_lim
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          stage_limit <= '0;
            else if (ld_stage)                   stage_limit <= ld_limit;
            else if (wr_ok && wr_addr == A_LIM)  stage_limit <= wr_data[CU_W-1:0];
         end
      end else begin : g_no_lim
         assign stage_limit = '0;
      end
   endgenerate

   assign mask_pad = BMW'(stage_mask);

   always_comb begin
      rd_data = '0;
      if (rd_addr == A_CTL) begin
         rd_data[OP_W-1:0]          = op;
         rd_data[AT_LSB +: AT_W]    = at;
         rd_data[ID_LSB +: ID_W]    = rcid;
         rd_data[ST_LSB +: ST_W]    = status;
         rd_data[BUSY_BIT]          = busy;
      end else if (rd_addr == A_LIM) begin
         rd_data[CU_W-1:0] = stage_limit;
      end else begin
         for (int w = 0; w < MASK_WORDS; w++) begin
            if (rd_addr == AW'(2 + w))
               rd_data = mask_pad[w*REG_W +: REG_W];
         end
      end
   end

   // R10: staging registers frozen while an operation runs (except read-back load)
   p_stage_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !ld_stage) |=> ($stable(stage_mask) && $stable(stage_limit)));

   // R10: control fields frozen while busy
   p_ctl_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(op) && $stable(rcid) && $stable(at)));
endmodule

// File: rtl/cap_alloc_table.sv
module cap_alloc_table
   import cap_alloc_pkg::*;
#(
   parameter int NBLK         = 16,
   parameter int NRCID        = 16,
   parameter int NAT_S        = 4,
   parameter int CU_W         = 20,
   parameter bit HAS_CU       = 1'b1,
   parameter bit REJECT_EMPTY = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [ID_W-1:0] w_rcid,
   input  logic [AT_W-1:0] w_at,
   input  logic [NBLK-1:0] w_mask,
   input  logic [CU_W-1:0] w_limit,
   input  logic [ID_W-1:0] a_rcid,
   input  logic [AT_W-1:0] a_at,
   output logic [NBLK-1:0] a_mask,
   output logic [CU_W-1:0] a_limit,
   input  logic [ID_W-1:0] b_rcid,
   input  logic [AT_W-1:0] b_at,
   output logic [NBLK-1:0] b_mask,
   output logic [CU_W-1:0] b_limit
);
   localparam int NENT = NRCID * NAT_S;

   logic [NBLK-1:0] mask_mem [NENT];
   logic            a_hit, b_hit;
   int              a_ent, b_ent, w_ent;

   function automatic int ent_of(input logic [ID_W-1:0] r, input logic [AT_W-1:0] a);
      return int'(r) * NAT_S + ((NAT_S > 1) ? int'(a) : 0);
   endfunction

   function automatic logic in_range(input logic [ID_W-1:0] r, input logic [AT_W-1:0] a);
      return (int'(r) < NRCID) && ((NAT_S == 1) || (int'(a) < NAT_S));
   endfunction

   assign a_hit = in_range(a_rcid, a_at);
   assign b_hit = in_range(b_rcid, b_at);
   assign a_ent = a_hit ? ent_of(a_rcid, a_at) : 0;
   assign b_ent = b_hit ? ent_of(b_rcid, b_at) : 0;
   assign w_ent = ent_of(w_rcid, w_at);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < NENT; e++)
            mask_mem[e] <= (e < NAT_S) ? '1 : '0;
      end else if (we && in_range(w_rcid, w_at)) begin
         mask_mem[w_ent] <= w_mask;
      end
   end

   assign a_mask = a_hit ? mask_mem[a_ent] : '0;
   assign b_mask = b_hit ? mask_mem[b_ent] : '0;

   generate
      if (HAS_CU) begin : g_lim
         logic [CU_W-1:0] lim_mem [NENT];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int e = 0; e < NENT; e++) lim_mem[e] <= '0;
            end else if (we && in_range(w_rcid, w_at)) begin
               lim_mem[w_ent] <= w_limit;
            end
         end
         assign a_limit = a_hit ? lim_mem[a_ent] : '0;
         assign b_limit = b_hit ? lim_mem[b_ent] : '0;
      end else begin : g_no_lim
         logic unused_lim;
         assign unused_lim = ^w_limit;
         assign a_limit    = '0;
         assign b_limit    = '0;
      end
   endgenerate

   generate
      if (REJECT_EMPTY) begin : g_chk_empty
         // R8: an empty mask never reaches the table
         p_no_empty_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
            we |-> (|w_mask));
      end
   endgenerate

   // R3: a table write always targets an in-range entry
   p_write_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (int'(w_rcid) < NRCID));
endmodule

// File: rtl/cap_alloc_seq.sv
module cap_alloc_seq
   import cap_alloc_pkg::*;
#(
   parameter int NRCID        = 16,
   parameter int NAT_S        = 4,
   parameter bit REJECT_EMPTY = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ctl_go,
   input  logic [OP_W-1:0] op,
   input  logic [AT_W-1:0] at,
   input  logic [ID_W-1:0] rcid,
   input  logic            mask_nz,
   input  logic            flush_ack,
   output logic            busy,
   output status_e         status,
   output logic            tbl_we,
   output logic            ld_stage,
   output logic            flush_req
);
   seq_state_e state_q;
   status_e    verdict;

   always_comb begin
      if (op != OPC_SET && op != OPC_GET && op != OPC_FLUSH)
         verdict = ST_BAD_OP;
      else if (int'(rcid) >= NRCID)
         verdict = ST_BAD_ID;
      else if (op != OPC_FLUSH && int'(at) >= NAT_S)
         verdict = ST_BAD_AT;
      else if (op == OPC_SET && REJECT_EMPTY && !mask_nz)
         verdict = ST_BAD_MASK;
      else
         verdict = ST_OK;
   end

   assign busy      = (state_q != SQ_IDLE);
   assign flush_req = (state_q == SQ_FLUSH);
   assign tbl_we    = (state_q == SQ_EXEC) && (verdict == ST_OK) && (op == OPC_SET);
   assign ld_stage  = (state_q == SQ_EXEC) && (verdict == ST_OK) && (op == OPC_GET);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         status  <= ST_NONE;
      end else begin
         unique case (state_q)
            SQ_IDLE: if (ctl_go) begin
               state_q <= SQ_EXEC;
               status  <= ST_NONE;
            end
            SQ_EXEC: begin
               if (verdict == ST_OK && op == OPC_FLUSH) begin
                  state_q <= SQ_FLUSH;
               end else begin
                  state_q <= SQ_IDLE;
                  status  <= verdict;
               end
            end
            SQ_FLUSH: if (flush_ack) begin
               state_q <= SQ_IDLE;
               status  <= ST_OK;
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   // R2: busy only rises after an accepted control write
   p_busy_from_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(ctl_go));

   // R2: a finished operation always leaves a completion code
   p_done_has_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (status != ST_NONE));

   // R11: request held until acknowledged
   p_flush_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_req && !flush_ack) |=> flush_req);

   // R11: acknowledge ends the operation with success
   p_flush_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_req && flush_ack) |=> (!busy && status == ST_OK));
endmodule

// File: rtl/cap_alloc_ctrl.sv
module cap_alloc_ctrl
   import cap_alloc_pkg::*;
#(
   parameter int NBLK         = 16,
   parameter int NRCID        = 16,
   parameter int NAT          = 4,
   parameter int CU_W         = 20,
   parameter bit PER_AT       = 1'b1,
   parameter bit HAS_CU       = 1'b1,
   parameter bit REJECT_EMPTY = 1'b1,
   localparam int MASK_WORDS  = (NBLK + 63) / 64,
   localparam int AW          = $clog2(2 + MASK_WORDS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_wr_en,
   input  logic [AW-1:0]   reg_wr_addr,
   input  logic [63:0]     reg_wr_data,
   input  logic [AW-1:0]   reg_rd_addr,
   output logic [63:0]     reg_rd_data,
   input  logic [11:0]     tbl_rcid,
   input  logic [2:0]      tbl_at,
   output logic [NBLK-1:0] tbl_mask,
   output logic [CU_W-1:0] tbl_limit,
   output logic            flush_req,
   output logic [11:0]     flush_rcid,
   input  logic            flush_ack
);
   localparam int NAT_S = PER_AT ? NAT : 1;

   generate
      if (NBLK < 1 || NBLK > 1024)           begin : g_e1 $error("NBLK out of range"); end
      if (NRCID < 1 || NRCID > 4096)         begin : g_e2 $error("NRCID out of range"); end
      if (NAT < 1 || NAT > 8)                begin : g_e3 $error("NAT out of range"); end
      if (CU_W < 1 || CU_W > 64)             begin : g_e4 $error("CU_W out of range"); end
      if (NRCID * NAT_S > 4096)              begin : g_e5 $error("table too large"); end
   endgenerate

   logic            ctl_go, busy, tbl_we, ld_stage;
   status_e         status;
   logic [OP_W-1:0] op;
   logic [AT_W-1:0] at;
   logic [ID_W-1:0] rcid;
   logic [NBLK-1:0] stage_mask, rb_mask;
   logic [CU_W-1:0] stage_limit, rb_limit;

   cap_alloc_regs #(
      .NBLK(NBLK), .MASK_WORDS(MASK_WORDS), .CU_W(CU_W),
      .HAS_CU(HAS_CU), .PER_AT(PER_AT), .AW(AW)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
      .rd_addr(reg_rd_addr), .rd_data(reg_rd_data),
      .busy(busy), .status(status),
      .ld_stage(ld_stage), .ld_mask(rb_mask), .ld_limit(rb_limit),
      .ctl_go(ctl_go), .op(op), .at(at), .rcid(rcid),
      .stage_mask(stage_mask), .stage_limit(stage_limit)
   );

   cap_alloc_table #(
      .NBLK(NBLK), .NRCID(NRCID), .NAT_S(NAT_S), .CU_W(CU_W),
      .HAS_CU(HAS_CU), .REJECT_EMPTY(REJECT_EMPTY)
   ) u_table (
      .clk(clk), .rst_n(rst_n),
      .we(tbl_we), .w_rcid(rcid), .w_at(at), .w_mask(stage_mask), .w_limit(stage_limit),
      .a_rcid(tbl_rcid), .a_at(tbl_at), .a_mask(tbl_mask), .a_limit(tbl_limit),
      .b_rcid(rcid), .b_at(at), .b_mask(rb_mask), .b_limit(rb_limit)
   );

   cap_alloc_seq #(
      .NRCID(NRCID), .NAT_S(NAT_S), .REJECT_EMPTY(REJECT_EMPTY)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .ctl_go(ctl_go), .op(op), .at(at), .rcid(rcid),
      .mask_nz(|stage_mask), .flush_ack(flush_ack),
      .busy(busy), .status(status), .tbl_we(tbl_we),
      .ld_stage(ld_stage), .flush_req(flush_req)
   );

   assign flush_rcid = rcid;
endmodule

// File: tb/sim_cap_alloc_ctrl.sv
module sim_cap_alloc_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NB = 16, NR = 16, NA = 4, CUW = 20;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0, rd_addr = '0;
   logic [63:0] wr_data = '0, rd_data;
   logic [11:0] tbl_rcid = '0, flush_rcid;
   logic [2:0]  tbl_at = '0;
   logic [NB-1:0]  tbl_mask;
   logic [CUW-1:0] tbl_limit;
   logic        flush_req, flush_ack = 1'b0;

   cap_alloc_ctrl u0 (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(wr_en), .reg_wr_addr(wr_addr), .reg_wr_data(wr_data),
      .reg_rd_addr(rd_addr), .reg_rd_data(rd_data),
      .tbl_rcid(tbl_rcid), .tbl_at(tbl_at), .tbl_mask(tbl_mask), .tbl_limit(tbl_limit),
      .flush_req(flush_req), .flush_rcid(flush_rcid), .flush_ack(flush_ack)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;
   logic [NB-1:0]  m_mask [NR][NA];
   logic [CUW-1:0] m_lim  [NR][NA];
   logic [NB-1:0]  stg_mask;
   logic [CUW-1:0] stg_lim;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [63:0] v);
      rd_addr = a; #1; v = rd_data;
   endtask

   task automatic wr(input logic [1:0] a, input logic [63:0] d);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   function automatic int exp_st(input int op, input int id, input int at, input logic [NB-1:0] m);
      if (op < 1 || op > 3)         return 2;
      if (id >= NR)                 return 3;
      if (op != 3 && at >= NA)      return 4;
      if (op == 1 && m == '0)       return 5;
      return 1;
   endfunction

   task automatic load_stage(input logic [NB-1:0] m, input logic [CUW-1:0] l);
      logic [63:0] v;
      logic [63:0] dm, dl;
      dm = {$urandom, $urandom}; dm[NB-1:0] = m;
      dl = {$urandom, $urandom}; dl[CUW-1:0] = l;
      wr(2, dm); wr(1, dl);
      stg_mask = m; stg_lim = l;
      rd(2, v); chk(v == 64'(m), "R9 mask upper bits zero", v, 64'(m));
      rd(1, v); chk(v == 64'(l), "R9 limit upper bits zero", v, 64'(l));
   endtask

   task automatic probe(input int id, input int at);
      logic [NB-1:0]  em;
      logic [CUW-1:0] el;
      tbl_rcid = 12'(id); tbl_at = 3'(at); #1;
      em = (id < NR && at < NA) ? m_mask[id][at] : '0;
      el = (id < NR && at < NA) ? m_lim[id][at]  : '0;
      chk(tbl_mask == em, "R3 lookup mask", 64'(tbl_mask), 64'(em));
      chk(tbl_limit == el, "R3 lookup limit", 64'(tbl_limit), 64'(el));
   endtask

   task automatic run_op(input int op, input int id, input int at, input int delay, input bit poke);
      logic [63:0] v, cw;
      int e;
      cw = '0; cw[4:0] = 5'(op); cw[7:5] = 3'(at); cw[19:8] = 12'(id);
      e = exp_st(op, id, at, stg_mask);
      wr(0, cw);
      rd(0, v);
      chk(v[39] == 1'b1, "R2 busy after write", 64'(v[39]), 64'd1);
      chk(v[19:0] == cw[19:0], "R2 control echo", v[19:0], cw[19:0]);
      if (poke) begin
         wr_en = 1'b1; wr_addr = 2; wr_data = {$urandom, $urandom};
      end
      if (e == 1 && op == 3) begin
         @(negedge clk); wr_en = 1'b0;
         chk(flush_req == 1'b1, "R11 flush request", 64'(flush_req), 64'd1);
         chk(flush_rcid == 12'(id), "R11 flush id", 64'(flush_rcid), 64'(id));
         for (int k = 0; k < delay; k++) begin
            wr_en = 1'b1; wr_addr = 2'($urandom % 3); wr_data = {$urandom, $urandom};
            @(negedge clk);
            wr_en = 1'b0;
            chk(flush_req == 1'b1, "R11 request held", 64'(flush_req), 64'd1);
         end
         flush_ack = 1'b1;
         @(negedge clk); flush_ack = 1'b0;
         rd(0, v);
         chk(v[39] == 1'b0 && v[38:32] == 7'd1, "R11 flush completion", v[39:32], 64'h01);
      end else begin
         @(negedge clk); wr_en = 1'b0;
         rd(0, v);
         chk(v[39] == 1'b0, "R2 busy cleared", 64'(v[39]), 64'd0);
         chk(int'(v[38:32]) == e, $sformatf("R%0s completion code", e == 2 ? "5" : e == 3 ? "6" : e == 4 ? "7" : e == 5 ? "8" : "3/4"),
             64'(v[38:32]), 64'(e));
      end
      rd(0, v);
      chk(v[19:0] == cw[19:0], "R10 control unchanged", v[19:0], cw[19:0]);
      if (e == 1 && op == 1) begin m_mask[id][at] = stg_mask; m_lim[id][at] = stg_lim; end
      if (e == 1 && op == 2) begin stg_mask = m_mask[id][at]; stg_lim = m_lim[id][at]; end
      rd(2, v); chk(v == 64'(stg_mask), "R4/R10 staged mask", v, 64'(stg_mask));
      rd(1, v); chk(v == 64'(stg_lim), "R4/R10 staged limit", v, 64'(stg_lim));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [63:0] v;
      void'($urandom(32'd4321));
      for (int r = 0; r < NR; r++)
         for (int a = 0; a < NA; a++) begin
            m_mask[r][a] = (r == 0) ? '1 : '0;
            m_lim[r][a]  = '0;
         end
      stg_mask = '0; stg_lim = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      rd(0, v); chk(v == 64'd0, "R1 control reset", v, 64'd0);
      for (int a = 0; a < NA; a++) probe(0, a);
      probe(5, 2);
      probe(NR, 0);
      // R8: empty mask rejected
      load_stage('0, 20'h123);
      run_op(1, 2, 1, 0, 0);
      probe(2, 1);
      // R5: bad op codes, including with bad id
      run_op(7, 1, 0, 0, 0);
      run_op(0, 1, 0, 0, 0);
      run_op(9, NR, 0, 0, 0);
      // R6 / R7
      load_stage(16'h00F0, 20'h55);
      run_op(2, NR, 0, 0, 0);
      run_op(1, 3, 5, 0, 0);
      probe(3, 4);
      // R3 / R4 configure then read back
      load_stage(16'h8001, 20'hABCDE);
      run_op(1, 15, 3, 0, 0);
      probe(15, 3);
      load_stage(16'h0F0F, 20'h1);
      run_op(2, 15, 3, 0, 0);
      run_op(2, 0, 2, 0, 0);
      // R10: write during execute cycle ignored
      load_stage(16'h00FF, 20'h77);
      run_op(1, 4, 0, 0, 1);
      probe(4, 0);
      // R11: flush with writes during the wait
      run_op(3, 3, 6, 5, 0);
      probe(4, 0);
      run_op(3, NR + 2, 0, 0, 0);
      // random mix
      for (int it = 0; it < 200; it++) begin
         int op, id, at, r;
         if ($urandom % 2 == 0)
            load_stage(($urandom % 10 == 0) ? '0 : NB'($urandom), CUW'($urandom));
         r  = $urandom % 10;
         op = (r == 0) ? (($urandom % 2 == 0) ? 0 : 4 + $urandom % 28) :
              (r <= 4) ? 1 : (r <= 7) ? 2 : (r == 8) ? 3 : 1;
         id = ($urandom % 6 == 0) ? NR + $urandom % 8 : $urandom % NR;
         at = ($urandom % 6 == 0) ? NA + $urandom % 4 : $urandom % NA;
         run_op(op, id, at, $urandom % 6, ($urandom % 4 == 0));
         probe($urandom % (NR + 2), $urandom % NA);
      end
      for (int r = 0; r < NR; r++) probe(r, $urandom % NA);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end
endmodule